// File: doc/BRIEF.md
# Card Activation and Supply-Level Sequencer

This block sits between a host's general-purpose control lines and the analog front end of a contact smart-card interface. The host gives one active-low session line. The timing of the edges on that line picks the card supply level. After a long idle high, a low held past a short qualifying time asks for the high supply. A low that comes back quickly after a rising edge asks for the low supply. Once a session is chosen, the block counts a fixed oscillator settle time and then turns the card supply on. After a short further delay it starts the card clock and enables the data line. From then on the card reset pin copies the host's reset request.

Teardown is automatic. The host can release the session line, or any one of four fault flags can be raised. Either event makes the block drop the card reset first, then stop the clock, then release the data line, then cut the supply, with one tick between each step. All time is counted in ticks of a timebase enable, nominally 1 µs. The default thresholds are 30000, 1000, 15000, 3200 and 270 ticks.

Top module: `card_act_seq`

## Requirements
- R1: With the session line high for at least IDLE_TICKS ticks, a low that is sampled on SHORT_TICKS+1 consecutive ticks starts a session with the high supply (supply_hi = 1). The start tick is the one carrying the (SHORT_TICKS+1)-th low sample.
- R2: A low sampled on the k-th tick after a rising edge that ended a session or a short qualifying pulse starts a low-supply session (supply_hi = 0) on that same tick when k <= REARM_TICKS. It is not accepted when k = REARM_TICKS+1.
- R3: From a qualified idle, a low lasting at most SHORT_TICKS samples starts nothing by itself. Its rising edge opens the R2 window.
- R4: A low that is neither qualified by the idle time nor inside an R2 window is ignored, and the line must return high before it can count again.
- R5: supply_on rises exactly OSC_TICKS ticks after the start tick. cclk_on, data_on and sess_live rise CLKDLY_TICKS ticks after that. cclk_on and data_on are never high without supply_on, and supply_hi stays constant while supply_on is high.
- R6: While sess_live is high, card_rst equals card_rst_req as it was one clock earlier, so a low-then-high on the request gives a warm reset. Outside a session, card_rst is 0.
- R7: A rising edge of the session line during a session or power-up, or any set bit of fault_flags on a tick, triggers teardown. The fault bits are: bit 0 card removed, bit 1 overtemperature, bit 2 supply overcurrent, bit 3 supply drop. On that tick sess_live and card_rst go low. cclk_on goes low one tick later, data_on two ticks later and supply_on three ticks later.
- R8: A start request is dropped while any fault bit is set, and also while the sequencer is not idle.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase enable, one clock wide per tick |
| sess_req_n | input | 1 | Active-low session command from the host |
| card_rst_req | input | 1 | Reset request from the host for the card |
| fault_flags | input | N_FAULT | Fault flags; any set bit forces teardown |
| supply_on | output | 1 | Card supply enable |
| supply_hi | output | 1 | Supply level select, 1 = high, 0 = low |
| cclk_on | output | 1 | Card clock enable |
| data_on | output | 1 | Card data line enable |
| card_rst | output | 1 | Card reset pin level |
| sess_live | output | 1 | Session fully powered and running |

## Verification
The properties assume that the session line and the fault flags matter only on tick cycles, and that a fault flag is held for a whole tick period when it is raised. They also assume card_rst_req may change on any clock, because the reset pass-through is checked clock by clock. The bench meets these assumptions. It changes every input only at a falling clock edge between ticks. It raises tick on every second clock, so each tick edge sees settled inputs, and it holds each fault until the teardown has run out.

// File: rtl/card_act_pkg.sv
package card_act_pkg;

  typedef enum logic [1:0] {
    DEC_HIGH,
    DEC_QUAL,
    DEC_SESS,
    DEC_IGN
  } dec_st_e;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_OSC,
    SEQ_RAMP,
    SEQ_LIVE,
    SEQ_DOWN
  } seq_st_e;

  // width of a counter that must hold values 0..maxv
  function automatic int unsigned cnt_w(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a rearm window still holding budget accepts a low sample
  function automatic logic window_open(input int unsigned left);
    return left != 0;
  endfunction

endpackage

// File: rtl/card_cmd_decode.sv
module card_cmd_decode
  import card_act_pkg::*;
#(
  parameter int unsigned IDLE_TICKS  = 30000,
  parameter int unsigned SHORT_TICKS = 1000,
  parameter int unsigned REARM_TICKS = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cmd_n,
  output logic start_hi,
  output logic start_lo,
  output logic stop_ev
);

  localparam int unsigned HI_W = cnt_w(IDLE_TICKS);
  localparam int unsigned LO_W = cnt_w(SHORT_TICKS);
  localparam int unsigned WN_W = cnt_w(REARM_TICKS);
  localparam logic [HI_W-1:0] HI_MAX = HI_W'(IDLE_TICKS);
  localparam logic [LO_W-1:0] LO_LIM = LO_W'(SHORT_TICKS);
  localparam logic [WN_W-1:0] WN_LEN = WN_W'(REARM_TICKS);

  dec_st_e         st_q, st_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;
  logic [WN_W-1:0] win_q, win_d;

  logic win_live;
  assign win_live = window_open(int'(win_q));

  assign start_lo = tick && (st_q == DEC_HIGH) && !cmd_n && win_live;
  assign start_hi = tick && (st_q == DEC_QUAL) && !cmd_n && (lo_q == LO_LIM);
  assign stop_ev  = tick && (st_q == DEC_SESS) && cmd_n;

  always_comb begin
    st_d  = st_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    win_d = win_q;
    if (tick) begin
      unique case (st_q)
        DEC_HIGH: begin
          if (!cmd_n) begin
            win_d = '0;
            if (win_live) begin
              st_d = DEC_SESS;
            end else if (hi_q == HI_MAX) begin
              st_d = DEC_QUAL;
              lo_d = LO_W'(1);
            end else begin
              st_d = DEC_IGN;
            end
          end else begin
            if (hi_q != HI_MAX) hi_d = hi_q + 1'b1;
            if (win_live) win_d = win_q - 1'b1;
          end
        end
        DEC_QUAL: begin
          if (cmd_n) begin
            st_d  = DEC_HIGH;
            hi_d  = HI_W'(1);
            win_d = WN_LEN;
          end else if (lo_q == LO_LIM) begin
            st_d = DEC_SESS;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
        DEC_SESS: begin
          if (cmd_n) begin
            st_d  = DEC_HIGH;
            hi_d  = HI_W'(1);
            win_d = WN_LEN;
          end
        end
        default: begin
          if (cmd_n) begin
            st_d  = DEC_HIGH;
            hi_d  = HI_W'(1);
            win_d = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DEC_HIGH;
      hi_q  <= '0;
      lo_q  <= '0;
      win_q <= '0;
    end else begin
      st_q  <= st_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      win_q <= win_d;
    end
  end

endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
  import card_act_pkg::*;
#(
  parameter int unsigned OSC_TICKS    = 3200,
  parameter int unsigned CLKDLY_TICKS = 270,
  parameter int unsigned N_FAULT      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start_hi,
  input  logic               start_lo,
  input  logic               stop_ev,
  input  logic [N_FAULT-1:0] fault_flags,
  input  logic               card_rst_req,
  output logic               supply_on,
  output logic               supply_hi,
  output logic               cclk_on,
  output logic               data_on,
  output logic               card_rst,
  output logic               sess_live
);

  localparam int unsigned CW = cnt_w(max2(OSC_TICKS, CLKDLY_TICKS));
  localparam logic [CW-1:0] OSC_LAST = CW'(OSC_TICKS - 1);
  localparam logic [CW-1:0] CLK_LAST = CW'(CLKDLY_TICKS - 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    step_q, step_d;
  logic          sup_d, lvl_d, clk_d, dat_d, rst_d;

  logic any_fault, want_start, abort;
  assign any_fault  = |fault_flags;
  assign want_start = tick && (start_hi || start_lo) && !any_fault;
  assign abort      = tick && (stop_ev || any_fault);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    step_d = step_q;
    sup_d  = supply_on;
    lvl_d  = supply_hi;
    clk_d  = cclk_on;
    dat_d  = data_on;
    unique case (st_q)
      SEQ_IDLE: begin
        if (want_start) begin
          st_d  = SEQ_OSC;
          cnt_d = '0;
          lvl_d = start_hi;
        end
      end
      SEQ_OSC: begin
        if (abort) begin
          st_d   = SEQ_DOWN;
          step_d = 2'd0;
        end else if (tick) begin
          if (cnt_q == OSC_LAST) begin
            st_d  = SEQ_RAMP;
            cnt_d = '0;
            sup_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SEQ_RAMP: begin
        if (abort) begin
          st_d   = SEQ_DOWN;
          step_d = 2'd0;
        end else if (tick) begin
          if (cnt_q == CLK_LAST) begin
            st_d  = SEQ_LIVE;
            clk_d = 1'b1;
            dat_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SEQ_LIVE: begin
        if (abort) begin
          st_d   = SEQ_DOWN;
          step_d = 2'd0;
        end
      end
      default: begin
        if (tick) begin
          unique case (step_q)
            2'd0: begin
              clk_d  = 1'b0;
              step_d = 2'd1;
            end
            2'd1: begin
              dat_d  = 1'b0;
              step_d = 2'd2;
            end
            default: begin
              sup_d = 1'b0;
              st_d  = SEQ_IDLE;
            end
          endcase
        end
      end
    endcase
    rst_d = (st_d == SEQ_LIVE) ? card_rst_req : 1'b0;
  end

  assign sess_live = (st_q == SEQ_LIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_IDLE;
      cnt_q     <= '0;
      step_q    <= 2'd0;
      supply_on <= 1'b0;
      supply_hi <= 1'b0;
      cclk_on   <= 1'b0;
      data_on   <= 1'b0;
      card_rst  <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      step_q    <= step_d;
      supply_on <= sup_d;
      supply_hi <= lvl_d;
      cclk_on   <= clk_d;
      data_on   <= dat_d;
      card_rst  <= rst_d;
    end
  end

endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
  import card_act_pkg::*;
#(
  parameter int unsigned IDLE_TICKS   = 30000,
  parameter int unsigned SHORT_TICKS  = 1000,
  parameter int unsigned REARM_TICKS  = 15000,
  parameter int unsigned OSC_TICKS    = 3200,
  parameter int unsigned CLKDLY_TICKS = 270,
  parameter int unsigned N_FAULT      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               sess_req_n,
  input  logic               card_rst_req,
  input  logic [N_FAULT-1:0] fault_flags,
  output logic               supply_on,
  output logic               supply_hi,
  output logic               cclk_on,
  output logic               data_on,
  output logic               card_rst,
  output logic               sess_live
);

  // decoder events, named so the checker can see them
  logic start_hi;
  logic start_lo;
  logic stop_ev;

  card_cmd_decode #(
    .IDLE_TICKS (IDLE_TICKS),
    .SHORT_TICKS(SHORT_TICKS),
    .REARM_TICKS(REARM_TICKS)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cmd_n   (sess_req_n),
    .start_hi(start_hi),
    .start_lo(start_lo),
    .stop_ev (stop_ev)
  );

  card_power_seq #(
    .OSC_TICKS   (OSC_TICKS),
    .CLKDLY_TICKS(CLKDLY_TICKS),
    .N_FAULT     (N_FAULT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .start_hi    (start_hi),
    .start_lo    (start_lo),
    .stop_ev     (stop_ev),
    .fault_flags (fault_flags),
    .card_rst_req(card_rst_req),
    .supply_on   (supply_on),
    .supply_hi   (supply_hi),
    .cclk_on     (cclk_on),
    .data_on     (data_on),
    .card_rst    (card_rst),
    .sess_live   (sess_live)
  );

endmodule

// File: rtl/card_act_seq_chk.sv
module card_act_seq_chk #(
  parameter int unsigned N_FAULT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               card_rst_req,
  input logic [N_FAULT-1:0] fault_flags,
  input logic               supply_on,
  input logic               supply_hi,
  input logic               cclk_on,
  input logic               data_on,
  input logic               card_rst,
  input logic               sess_live,
  input logic               start_hi,
  input logic               start_lo
);

  // R1 R2
  one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_hi && start_lo));

  // R5
  clk_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_on |-> supply_on);

  // R5
  data_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_on |-> supply_on);

  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_on && $past(supply_on)) |-> $stable(supply_hi));

  // R6
  rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sess_live |-> (card_rst == $past(card_rst_req)));

  // R6
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_live |-> !card_rst);

  // R7
  fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sess_live && (|fault_flags)) |=> !sess_live);

  // R7
  clk_stop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk_on) |-> (supply_on && data_on && !card_rst));

  // R7
  supply_off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_on) |-> (!cclk_on && !data_on));

  // R8
  fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fault_flags) && !supply_on) |=> !supply_on);

endmodule

bind card_act_seq card_act_seq_chk #(.N_FAULT(N_FAULT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .card_rst_req(card_rst_req),
  .fault_flags (fault_flags),
  .supply_on   (supply_on),
  .supply_hi   (supply_hi),
  .cclk_on     (cclk_on),
  .data_on     (data_on),
  .card_rst    (card_rst),
  .sess_live   (sess_live),
  .start_hi    (start_hi),
  .start_lo    (start_lo)
);

// File: tb/card_act_seq_bench.sv
module card_act_seq_bench;

  localparam int IDLE  = 40;
  localparam int SHORT = 5;
  localparam int REARM = 20;
  localparam int OSC   = 30;
  localparam int CLKD  = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       sess_req_n;
  logic       card_rst_req;
  logic [3:0] fault_flags;
  logic       supply_on, supply_hi, cclk_on, data_on, card_rst, sess_live;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  card_act_seq #(
    .IDLE_TICKS  (IDLE),
    .SHORT_TICKS (SHORT),
    .REARM_TICKS (REARM),
    .OSC_TICKS   (OSC),
    .CLKDLY_TICKS(CLKD),
    .N_FAULT     (4)
  ) u_card_act_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .sess_req_n  (sess_req_n),
    .card_rst_req(card_rst_req),
    .fault_flags (fault_flags),
    .supply_on   (supply_on),
    .supply_hi   (supply_hi),
    .cclk_on     (cclk_on),
    .data_on     (data_on),
    .card_rst    (card_rst),
    .sess_live   (sess_live)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one tick period: two clocks, one tick edge
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic watch_none(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tk(1);
      if (supply_on) seen++;
    end
    chk(req, "supply stayed off", seen, 0);
  endtask

  // called right after the start tick
  task automatic wait_live(input int lvl, input string req);
    tk(OSC - 1);
    chk("R5", "supply before settle end", supply_on, 0);
    tk(1);
    chk("R5", "supply at settle end", supply_on, 1);
    chk(req, "supply level", supply_hi, lvl);
    chk("R5", "clock before delay", cclk_on, 0);
    tk(CLKD - 1);
    chk("R5", "clock one tick early", cclk_on, 0);
    tk(1);
    chk("R5", "clock on", cclk_on, 1);
    chk("R5", "data on", data_on, 1);
    chk("R5", "session live", sess_live, 1);
  endtask

  // called right after the tick that triggered teardown
  task automatic down_check(input string req);
    chk(req, "live dropped", sess_live, 0);
    chk(req, "reset low first", card_rst, 0);
    chk(req, "clock kept one tick", cclk_on, 1);
    tk(1);
    chk(req, "clock stopped", cclk_on, 0);
    chk(req, "data kept", data_on, 1);
    tk(1);
    chk(req, "data released", data_on, 0);
    chk(req, "supply kept", supply_on, 1);
    tk(1);
    chk(req, "supply off", supply_on, 0);
  endtask

  task automatic t_reset();
    chk("R9", "supply_on", supply_on, 0);
    chk("R9", "supply_hi", supply_hi, 0);
    chk("R9", "cclk_on", cclk_on, 0);
    chk("R9", "data_on", data_on, 0);
    chk("R9", "card_rst", card_rst, 0);
    chk("R9", "sess_live", sess_live, 0);
  endtask

  task automatic t_early_low();
    tk(5);
    sess_req_n = 1'b0;
    watch_none(SHORT + OSC + CLKD + 3, "R4");
    sess_req_n = 1'b1;
    tk(2);
    sess_req_n = 1'b0;
    watch_none(SHORT + OSC + CLKD + 3, "R4");
    sess_req_n = 1'b1;
  endtask

  task automatic t_high_level();
    tk(IDLE + 2);
    sess_req_n = 1'b0;
    tk(1);
    tk(SHORT);
    wait_live(1, "R1");
    chk("R6", "reset idle low", card_rst, 0);
  endtask

  task automatic t_reset_pass();
    card_rst_req = 1'b1;
    tk(1);
    chk("R6", "reset follows high", card_rst, 1);
    card_rst_req = 1'b0;
    tk(1);
    chk("R6", "warm reset low", card_rst, 0);
    card_rst_req = 1'b1;
    tk(1);
    chk("R6", "warm reset high", card_rst, 1);
  endtask

  task automatic t_stop_then_low();
    sess_req_n = 1'b1;
    tk(1);
    down_check("R7");
    chk("R6", "reset low outside session", card_rst, 0);
    card_rst_req = 1'b0;
    tk(REARM - 4);
    sess_req_n = 1'b0;
    tk(1);
    wait_live(0, "R2");
  endtask

  task automatic t_window_expiry();
    sess_req_n = 1'b1;
    tk(1);
    down_check("R7");
    tk(REARM - 3);
    sess_req_n = 1'b0;
    watch_none(OSC + CLKD + 2, "R2");
    sess_req_n = 1'b1;
    tk(IDLE + 2);
  endtask

  task automatic t_short_pulse();
    sess_req_n = 1'b0;
    tk(SHORT);
    sess_req_n = 1'b1;
    tk(3);
    chk("R3", "short pulse alone", supply_on, 0);
    sess_req_n = 1'b0;
    tk(1);
    wait_live(0, "R3");
    sess_req_n = 1'b1;
    tk(1);
    down_check("R7");
  endtask

  task automatic t_faults();
    for (int b = 0; b < 4; b++) begin
      sess_req_n = 1'b0;
      tk(1);
      wait_live(0, "R2");
      fault_flags = 4'(1 << b);
      tk(1);
      down_check("R7");
      fault_flags = 4'd0;
      sess_req_n = 1'b1;
      tk(3);
    end
  endtask

  task automatic t_fault_block();
    fault_flags = 4'b1000;
    sess_req_n = 1'b0;
    watch_none(OSC + CLKD + 2, "R8");
    fault_flags = 4'd0;
    sess_req_n = 1'b1;
    tk(3);
  endtask

  task automatic t_abort_early();
    sess_req_n = 1'b0;
    tk(1);
    tk(5);
    fault_flags = 4'b0100;
    tk(1);
    fault_flags = 4'd0;
    watch_none(OSC + CLKD + 2, "R7");
    sess_req_n = 1'b1;
    tk(3);
  endtask

  task automatic t_busy_drop();
    int live_seen = 0;
    sess_req_n = 1'b0;
    tk(1);
    wait_live(0, "R2");
    sess_req_n = 1'b1;
    tk(1);
    sess_req_n = 1'b0;
    for (int i = 0; i < OSC + CLKD + 4; i++) begin
      tk(1);
      if (sess_live) live_seen++;
    end
    chk("R8", "start during teardown dropped", live_seen, 0);
    chk("R8", "supply off after drop", supply_on, 0);
    sess_req_n = 1'b1;
    tk(2);
  endtask

  initial begin
    rst_n        = 1'b0;
    tick         = 1'b0;
    sess_req_n   = 1'b1;
    card_rst_req = 1'b0;
    fault_flags  = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_early_low();
    t_high_level();
    t_reset_pass();
    t_stop_then_low();
    t_window_expiry();
    t_short_pulse();
    t_faults();
    t_fault_block();
    t_abort_early();
    t_busy_drop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule